// File: doc/BRIEF.md
# Interrupt Status and Mask Controller

This block gathers six event sources of a fuse-array controller (bus slave error, cache error, read error, read done, program error and program done) into one level interrupt line. Each source owns one bit of a 32-bit status word. A hardware event raises the bit, and a separate hardware clear strobe lowers it. Software lowers it by writing a 1 to that bit.

The mask word decides which raised bits reach the interrupt. Software cannot write the mask directly. It turns bits on through an enable alias, which ORs the written bits into the mask. It turns bits off through a disable alias, which removes the written bits. Both aliases hold no state of their own. The interrupt output is a register that follows the OR of (status AND mask) from the same clock edge that updates status or mask.

The register port is a simple one: a write strobe with a word address and data, and a read strobe whose data appears one cycle later. Word addresses: 0 status, 1 mask, 2 enable alias, 3 disable alias.

Top module: `irq_mask_ctrl`

## Requirements
- R1: After reset, status reads 0x00000000, mask reads 0x8000001F, and the interrupt output is low.
- R2: A set strobe on source index i raises status bit i for indices 0 to 4 and bit 31 for index 5, at the next clock edge.
- R3: Writing status (address 0) clears each source bit written as 1 and leaves bits written as 0 unchanged.
- R4: When a set strobe and a software write of 1 hit the same status bit in the same cycle, the bit ends up set.
- R5: A clear strobe on a source lowers its status bit at the next edge unless its set strobe is also active.
- R6: A write to the mask address (address 1) leaves the mask unchanged.
- R7: A write to the enable alias (address 2) ORs the written source bits into the mask.
- R8: A write to the disable alias (address 3) clears the written source bits in the mask.
- R9: Reads of the enable and disable aliases return zero.
- R10: The interrupt output equals the OR of (status AND mask) and changes on the same clock edge as the status or mask change that causes it.
- R11: Bits 5 to 30 read as zero in status and mask, and writing them to any address has no effect.
- R12: Read data appears on the clock edge that samples the read strobe and holds until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Word address of the write |
| wr_data | input | 32 | Write data |
| rd_en | input | 1 | Register read strobe |
| rd_addr | input | 2 | Word address of the read |
| rd_data | output | 32 | Registered read data |
| evt_set | input | 6 | Per-source set strobes (index 5 maps to bit 31) |
| evt_clr | input | 6 | Per-source clear strobes |
| irq | output | 1 | Level interrupt output |

## Verification
The bench targets the case where a hardware set and a software clear land in the same cycle. A design that let the clear win would lose an event and read the bit as zero. It also writes straight to the mask address. A design that treated the mask as a plain register would drop every source and silence the interrupt. The split bit mapping, with source 5 at bit 31, is checked by raising each source on its own. Reserved bits are written through every address: a design that stored them would read them back, and one that misrouted them could flip a neighbouring source. The bench also samples the interrupt in the cycle the status or mask changes, to catch a design that adds an extra register stage.

// File: rtl/irqm_pkg.sv
package irqm_pkg;

  typedef enum logic [1:0] {
    REG_STATUS = 2'd0,
    REG_MASK   = 2'd1,
    REG_SETEN  = 2'd2,
    REG_CLREN  = 2'd3
  } reg_sel_e;

  // Bit position of source index i in a word of width w with n sources:
  // the last source sits at the top bit, the others pack from bit 0.
  function automatic int src_pos(int i, int w, int n);
    return (i == n - 1) ? (w - 1) : i;
  endfunction

  // Word with a 1 at every source position.
  function automatic logic [63:0] src_bits(int w, int n);
    logic [63:0] v;
    v = '0;
    for (int i = 0; i < n; i++) v[src_pos(i, w, n)] = 1'b1;
    return v;
  endfunction

endpackage

// File: rtl/irqm_status_bank.sv
module irqm_status_bank #(
  parameter int NUM_SRC = 6
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_SRC-1:0] evt_set,
  input  logic [NUM_SRC-1:0] evt_clr,
  input  logic [NUM_SRC-1:0] sw_clr,
  output logic [NUM_SRC-1:0] stat_d,
  output logic [NUM_SRC-1:0] stat_q
);

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_bit
    // Set wins over both clear paths.
    assign stat_d[i] = evt_set[i] | (stat_q[i] & ~evt_clr[i] & ~sw_clr[i]);

    always_ff @(posedge clk) begin
      if (rst) stat_q[i] <= 1'b0;
      else     stat_q[i] <= stat_d[i];
    end

    // R4: a set strobe always leaves the bit raised
    a_r4_set_wins: assert property (@(posedge clk) disable iff (rst)
      evt_set[i] |=> stat_q[i]);

    // R3/R5: a clear from either path without a set lowers the bit
    a_r5_clear_lowers: assert property (@(posedge clk) disable iff (rst)
      ((evt_clr[i] || sw_clr[i]) && !evt_set[i]) |=> !stat_q[i]);
  end

endmodule

// File: rtl/irqm_mask_bank.sv
module irqm_mask_bank #(
  parameter int               NUM_SRC = 6,
  parameter logic [NUM_SRC-1:0] RST_VAL = '1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_SRC-1:0] en_bits,
  input  logic [NUM_SRC-1:0] dis_bits,
  output logic [NUM_SRC-1:0] mask_d,
  output logic [NUM_SRC-1:0] mask_q
);

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_bit
    assign mask_d[i] = en_bits[i] | (mask_q[i] & ~dis_bits[i]);

    always_ff @(posedge clk) begin
      if (rst) mask_q[i] <= RST_VAL[i];
      else     mask_q[i] <= mask_d[i];
    end
  end

  // R6: without an alias write the mask holds
  a_r6_mask_holds: assert property (@(posedge clk) disable iff (rst)
    (en_bits == '0 && dis_bits == '0) |=> $stable(mask_q));

  // R7: enabled bits are present afterwards
  a_r7_enable_or: assert property (@(posedge clk) disable iff (rst)
    (en_bits != '0) |=> ((mask_q & $past(en_bits)) == $past(en_bits)));

  // R8: disabled bits are gone afterwards
  a_r8_disable_clear: assert property (@(posedge clk) disable iff (rst)
    (dis_bits != '0 && en_bits == '0) |=> ((mask_q & $past(dis_bits)) == '0));

endmodule

// File: rtl/irqm_readback.sv
module irqm_readback #(
  parameter int DATA_W = 32
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 rd_en,
  input  irqm_pkg::reg_sel_e   rd_sel,
  input  logic [DATA_W-1:0]    stat_word,
  input  logic [DATA_W-1:0]    mask_word,
  output logic [DATA_W-1:0]    rd_data
);
  import irqm_pkg::*;

  logic [DATA_W-1:0] sel_word;

  always_comb begin
    unique case (rd_sel)
      REG_STATUS: sel_word = stat_word;
      REG_MASK:   sel_word = mask_word;
      default:    sel_word = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)        rd_data <= '0;
    else if (rd_en) rd_data <= sel_word;
  end

  // R12: data holds between reads
  a_r12_hold: assert property (@(posedge clk) disable iff (rst)
    !rd_en |=> $stable(rd_data));

  // R9: alias reads return zero
  a_r9_alias_zero: assert property (@(posedge clk) disable iff (rst)
    (rd_en && (rd_sel == REG_SETEN || rd_sel == REG_CLREN)) |=> (rd_data == '0));

endmodule

// File: rtl/irq_mask_ctrl.sv
module irq_mask_ctrl #(
  parameter int DATA_W  = 32,
  parameter int NUM_SRC = 6,
  parameter int ADDR_W  = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data,
  input  logic [NUM_SRC-1:0] evt_set,
  input  logic [NUM_SRC-1:0] evt_clr,
  output logic              irq
);
  import irqm_pkg::*;

  localparam logic [DATA_W-1:0] VALID = DATA_W'(src_bits(DATA_W, NUM_SRC));

  reg_sel_e wr_sel, rd_sel;
  assign wr_sel = reg_sel_e'(wr_addr[1:0]);
  assign rd_sel = reg_sel_e'(rd_addr[1:0]);

  logic [NUM_SRC-1:0] wsrc, sw_clr, en_bits, dis_bits;
  logic [NUM_SRC-1:0] stat_d, stat_q, mask_d, mask_q;
  logic [DATA_W-1:0]  stat_word, mask_word;

  // Gather source bits from the written word, and spread state back out.
  always_comb begin
    stat_word = '0;
    mask_word = '0;
    for (int i = 0; i < NUM_SRC; i++) begin
      wsrc[i] = wr_data[src_pos(i, DATA_W, NUM_SRC)];
      stat_word[src_pos(i, DATA_W, NUM_SRC)] = stat_q[i];
      mask_word[src_pos(i, DATA_W, NUM_SRC)] = mask_q[i];
    end
  end

  assign sw_clr   = (wr_en && wr_sel == REG_STATUS) ? wsrc : '0;
  assign en_bits  = (wr_en && wr_sel == REG_SETEN)  ? wsrc : '0;
  assign dis_bits = (wr_en && wr_sel == REG_CLREN)  ? wsrc : '0;

  irqm_status_bank #(.NUM_SRC(NUM_SRC)) u_status (
    .clk(clk), .rst(rst), .evt_set(evt_set), .evt_clr(evt_clr),
    .sw_clr(sw_clr), .stat_d(stat_d), .stat_q(stat_q)
  );

  irqm_mask_bank #(.NUM_SRC(NUM_SRC), .RST_VAL('1)) u_mask (
    .clk(clk), .rst(rst), .en_bits(en_bits), .dis_bits(dis_bits),
    .mask_d(mask_d), .mask_q(mask_q)
  );

  irqm_readback #(.DATA_W(DATA_W)) u_rd (
    .clk(clk), .rst(rst), .rd_en(rd_en), .rd_sel(rd_sel),
    .stat_word(stat_word), .mask_word(mask_word), .rd_data(rd_data)
  );

  // Registered output built from next state, so it lands on the same edge.
  always_ff @(posedge clk) begin
    if (rst) irq <= 1'b0;
    else     irq <= |(stat_d & mask_d);
  end

  // R10: output tracks the registered status and mask
  a_r10_irq_match: assert property (@(posedge clk) disable iff (rst)
    irq == |(stat_word & mask_word));

  // R11: reserved bits never reach the read path
  a_r11_reserved_zero: assert property (@(posedge clk) disable iff (rst)
    ((rd_data & ~VALID) == '0));

endmodule

// File: tb/sim_irq_mask_ctrl.sv
module sim_irq_mask_ctrl;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic        rd_en = 1'b0;
  logic [1:0]  rd_addr = '0;
  logic [31:0] rd_data;
  logic [5:0]  evt_set = '0;
  logic [5:0]  evt_clr = '0;
  logic        irq;

  int n_cmp = 0;
  int n_bad = 0;

  always #4 clk = ~clk;

  irq_mask_ctrl u0 (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data),
    .evt_set(evt_set), .evt_clr(evt_clr), .irq(irq)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // One-cycle operation: optional write and events in the same cycle.
  task automatic cycle(logic we, logic [1:0] a, logic [31:0] d,
                       logic [5:0] s, logic [5:0] c);
    @(negedge clk);
    wr_en = we; wr_addr = a; wr_data = d; evt_set = s; evt_clr = c;
    @(posedge clk); #2;
    @(negedge clk);
    wr_en = 1'b0; evt_set = '0; evt_clr = '0;
  endtask

  task automatic rd(logic [1:0] a, output logic [31:0] v);
    @(negedge clk);
    rd_en = 1'b1; rd_addr = a;
    @(posedge clk); #2;
    v = rd_data;
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic t_reset();
    logic [31:0] v;
    check("R1 irq", {31'd0, irq}, 32'd0);
    rd(2'd0, v); check("R1 status", v, 32'h0);
    rd(2'd1, v); check("R1 mask", v, 32'h8000001F);
  endtask

  task automatic t_mapping();
    logic [31:0] v;
    // R2/R10: single source, irq must rise on the same edge
    @(negedge clk); evt_set = 6'b000100;
    @(posedge clk); #2;
    check("R10 irq same edge", {31'd0, irq}, 32'd1);
    @(negedge clk); evt_set = '0;
    rd(2'd0, v); check("R2 src2 bit2", v, 32'h4);
    cycle(1'b0, 2'd0, 32'h0, 6'b100000, 6'b0);
    rd(2'd0, v); check("R2 src5 bit31", v, 32'h80000004);
    cycle(1'b0, 2'd0, 32'h0, 6'b011011, 6'b0);
    rd(2'd0, v); check("R2 all", v, 32'h8000001F);
  endtask

  task automatic t_w1c();
    logic [31:0] v;
    cycle(1'b1, 2'd0, 32'h80000004, '0, '0);
    rd(2'd0, v); check("R3 w1c", v, 32'h0000001B);
    cycle(1'b1, 2'd0, 32'h0, '0, '0);
    rd(2'd0, v); check("R3 zeros keep", v, 32'h0000001B);
    cycle(1'b1, 2'd0, 32'h7FFFFFE0, '0, '0);
    rd(2'd0, v); check("R11 reserved status", v, 32'h0000001B);
  endtask

  task automatic t_set_wins();
    logic [31:0] v;
    cycle(1'b1, 2'd0, 32'h00000002, 6'b000010, '0);
    rd(2'd0, v); check("R4 set beats w1c", v, 32'h0000001B);
    cycle(1'b0, 2'd0, 32'h0, 6'b001000, 6'b001000);
    rd(2'd0, v); check("R5 set beats hw clr", v, 32'h0000001B);
  endtask

  task automatic t_hw_clear();
    logic [31:0] v;
    cycle(1'b0, 2'd0, 32'h0, '0, 6'b001001);
    rd(2'd0, v); check("R5 hw clear", v, 32'h00000012);
  endtask

  task automatic t_mask();
    logic [31:0] v;
    cycle(1'b1, 2'd1, 32'h0, '0, '0);
    rd(2'd1, v); check("R6 direct write ignored", v, 32'h8000001F);
    check("R6 irq still high", {31'd0, irq}, 32'd1);
    @(negedge clk); wr_en = 1'b1; wr_addr = 2'd3; wr_data = 32'hFFFFFFFF;
    @(posedge clk); #2;
    check("R10 irq drops same edge", {31'd0, irq}, 32'd0);
    @(negedge clk); wr_en = 1'b0;
    rd(2'd1, v); check("R8 disable all", v, 32'h0);
    cycle(1'b1, 2'd2, 32'h00000004, '0, '0);
    rd(2'd1, v); check("R7 enable bit2", v, 32'h4);
    check("R10 masked out (status bit2 low)", {31'd0, irq}, 32'd0);
    cycle(1'b1, 2'd2, 32'h80000000, '0, '0);
    rd(2'd1, v); check("R7 enable OR", v, 32'h80000004);
    cycle(1'b1, 2'd2, 32'h7FFFFFE0, '0, '0);
    rd(2'd1, v); check("R11 reserved mask", v, 32'h80000004);
    cycle(1'b0, 2'd0, 32'h0, 6'b000100, '0);
    check("R10 irq via bit2", {31'd0, irq}, 32'd1);
    cycle(1'b1, 2'd3, 32'h00000004, '0, '0);
    rd(2'd1, v); check("R8 disable bit2", v, 32'h80000000);
    check("R10 irq low", {31'd0, irq}, 32'd0);
    rd(2'd2, v); check("R9 enable reads zero", v, 32'h0);
    rd(2'd3, v); check("R9 disable reads zero", v, 32'h0);
    @(negedge clk); @(negedge clk);
    check("R12 read data held", rd_data, 32'h0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    t_reset();
    t_mapping();
    t_w1c();
    t_set_wins();
    t_hw_clear();
    t_mask();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule